// File: doc/BRIEF.md
# Edge Change Interrupt Unit

The unit watches a bank of asynchronous digital inputs, organised as ports of eight channels, for rising and falling transitions. Every channel has its own rising-arm and falling-arm bit. A global control byte gates detection as a whole and each edge direction. Qualifying edges set sticky flags and can raise a single interrupt line. Software reads a status byte and acknowledges events by writing ones to a clear byte.

A second qualifying edge that arrives while the first is still unacknowledged can be recorded in a separate overflow flag, so software can tell that events were merged. All registers sit behind a byte-wide write port with a combinational read path. Inputs are taken through a two-flop synchroniser before any edge is judged.

Top module: `edge_irq_unit`

## Requirements
- R1: After reset the control byte, every arm byte and every status flag read 0x00, and `irq` is low.
- R2: Port p has its rising-arm byte at address 0x42+0x10·p and its falling-arm byte at 0x43+0x10·p. Both read back the value written. Channel c is bit c%8 of port c/8, and `in_raw[c]` is the input of channel c.
- R3: A low-to-high change on an armed channel sets status bit0 (edge flag) and bit3 (rise seen), provided control bit0 (detect) and bit3 (global rise) are both set.
- R4: A high-to-low change on an armed channel sets status bit0 and bit4 (fall seen), provided control bit0 and bit4 (global fall) are both set.
- R5: An edge sets no flag in any of these cases: its channel's arm bit for that direction is clear, the matching global direction bit is clear, or control bit0 is clear. A control byte of 0x00 therefore blocks all detection.
- R6: `irq` is high exactly when control bit2 (interrupt enable) and the edge flag are both set. Status bit2 reads the same value as `irq`.
- R7: Writing to address 0x01 clears flags selectively. Bit3 = 1 clears the edge flag and both seen flags. Bit2 = 1 clears the overflow flag. Bits written as 0 leave their flags unchanged.
- R8: A qualifying edge while the edge flag is already set sets status bit1 (overflow), but only if control bit1 is set. With control bit1 clear, no overflow flag is raised.
- R9: If a qualifying edge and a write of 1 to clear bit3 land on the same clock edge, the edge flag stays set and no overflow is recorded.
- R10: An input change first appears in the status byte on the third rising clock edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_raw | input | NUM_PORTS*8 | Asynchronous channel inputs |
| bus_addr | input | ADDR_W | Register address for read and write |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench arms channels in one direction only and then toggles them the other way. A design that ignores the per-channel direction bits would flag those edges. It hits an already-set edge flag with overflow reporting both on and off. A design that set overflow unconditionally, or never set it, shows up there. It aligns a rising edge with a clear write on the same clock edge. A design that lets the clear win would drop an event, and one that judges overflow from the old flag would report a false overflow. It samples the status one cycle before and exactly on the expected latency, so an extra or missing synchroniser stage is caught. Partial clears with a zero byte and with only the overflow bit confirm that each clear bit touches only its own flag.

// File: rtl/eiu_pkg.sv
package eiu_pkg;
    localparam int ADDR_CLEAR   = 'h01;
    localparam int ADDR_STATUS  = 'h02;
    localparam int ADDR_CONTROL = 'h03;
    localparam int RISE_BASE    = 'h42;
    localparam int FALL_BASE    = 'h43;
    localparam int PORT_STRIDE  = 'h10;
    localparam int PORT_BITS    = 8;

    // control byte, bit 4 down to bit 0
    typedef struct packed {
        logic glb_fall;
        logic glb_rise;
        logic int_en;
        logic ovf_en;
        logic det_en;
    } ctrl_t;

    typedef struct packed {
        logic fall_seen;
        logic rise_seen;
        logic ovf;
        logic edge_f;
    } flags_t;
endpackage

// File: rtl/eiu_sync.sv
module eiu_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = din;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign dout = sy_q.s2;
endmodule

// File: rtl/eiu_port_regs.sv
module eiu_port_regs
    import eiu_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 8,
    localparam int CH       = NUM_PORTS * PORT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [CH-1:0]     rise_arm,
    output logic [CH-1:0]     fall_arm,
    output logic              rd_hit,
    output logic [7:0]        rd_data
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] RA = ADDR_W'(RISE_BASE + PORT_STRIDE * p);
        localparam logic [ADDR_W-1:0] FA = ADDR_W'(FALL_BASE + PORT_STRIDE * p);

        typedef struct packed {
            logic [7:0] rise;
            logic [7:0] fall;
        } arm_t;

        arm_t arm_d, arm_q;

        always_comb begin
            arm_d = arm_q;
            if (bus_wr && bus_addr == RA) arm_d.rise = bus_wdata;
            if (bus_wr && bus_addr == FA) arm_d.fall = bus_wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) arm_q <= '0;
            else        arm_q <= arm_d;
        end

        assign rise_arm[p*PORT_BITS +: PORT_BITS] = arm_q.rise;
        assign fall_arm[p*PORT_BITS +: PORT_BITS] = arm_q.fall;
    end

    always_comb begin
        rd_hit  = 1'b0;
        rd_data = 8'h00;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == ADDR_W'(RISE_BASE + PORT_STRIDE * p)) begin
                rd_hit  = 1'b1;
                rd_data = rise_arm[p*PORT_BITS +: PORT_BITS];
            end
            if (bus_addr == ADDR_W'(FALL_BASE + PORT_STRIDE * p)) begin
                rd_hit  = 1'b1;
                rd_data = fall_arm[p*PORT_BITS +: PORT_BITS];
            end
        end
    end
endmodule

// File: rtl/eiu_edge_qual.sv
module eiu_edge_qual
    import eiu_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int CH       = NUM_PORTS * PORT_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] cur,
    input  logic [CH-1:0] rise_arm,
    input  logic [CH-1:0] fall_arm,
    input  logic          det_en,
    input  logic          glb_rise,
    input  logic          glb_fall,
    output logic          rise_hit,
    output logic          fall_hit
);
    typedef struct packed {
        logic [CH-1:0] prev;
    } hist_t;

    hist_t h_d, h_q;
    logic [NUM_PORTS-1:0] port_rise, port_fall;

    always_comb begin
        h_d      = h_q;
        h_d.prev = cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [7:0] now_b, old_b;
        assign now_b = cur[p*PORT_BITS +: PORT_BITS];
        assign old_b = h_q.prev[p*PORT_BITS +: PORT_BITS];
        assign port_rise[p] = |( now_b & ~old_b & rise_arm[p*PORT_BITS +: PORT_BITS]);
        assign port_fall[p] = |(~now_b &  old_b & fall_arm[p*PORT_BITS +: PORT_BITS]);
    end

    assign rise_hit = det_en & glb_rise & (|port_rise);
    assign fall_hit = det_en & glb_fall & (|port_fall);
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
    import eiu_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 8,
    localparam int CH       = NUM_PORTS * PORT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH-1:0]     in_raw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    typedef struct packed {
        ctrl_t  ctrl;
        flags_t flg;
    } core_t;

    core_t c_d, c_q;

    logic [CH-1:0] in_sync, rise_arm, fall_arm;
    logic          rise_hit, fall_hit, port_rd_hit;
    logic [7:0]    port_rd_data;
    logic [7:0]    ctrl_byte, stat_byte;
    logic          clr_wr, clr_edge, clr_ovf, edge_kept;

    eiu_sync #(.WIDTH(CH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (in_raw),
        .dout (in_sync)
    );

    eiu_port_regs #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .rise_arm (rise_arm),
        .fall_arm (fall_arm),
        .rd_hit   (port_rd_hit),
        .rd_data  (port_rd_data)
    );

    eiu_edge_qual #(.NUM_PORTS(NUM_PORTS)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (in_sync),
        .rise_arm(rise_arm),
        .fall_arm(fall_arm),
        .det_en  (c_q.ctrl.det_en),
        .glb_rise(c_q.ctrl.glb_rise),
        .glb_fall(c_q.ctrl.glb_fall),
        .rise_hit(rise_hit),
        .fall_hit(fall_hit)
    );

    assign clr_wr    = bus_wr && (bus_addr == ADDR_W'(ADDR_CLEAR));
    assign clr_edge  = clr_wr && bus_wdata[3];
    assign clr_ovf   = clr_wr && bus_wdata[2];
    assign edge_kept = c_q.flg.edge_f && !clr_edge;

    always_comb begin
        c_d = c_q;
        if (bus_wr && bus_addr == ADDR_W'(ADDR_CONTROL))
            c_d.ctrl = ctrl_t'(bus_wdata[4:0]);
        if (clr_edge) begin
            c_d.flg.edge_f    = 1'b0;
            c_d.flg.rise_seen = 1'b0;
            c_d.flg.fall_seen = 1'b0;
        end
        if (clr_ovf) c_d.flg.ovf = 1'b0;
        // a new edge beats a same-cycle clear
        if (rise_hit || fall_hit) begin
            c_d.flg.edge_f = 1'b1;
            if (rise_hit) c_d.flg.rise_seen = 1'b1;
            if (fall_hit) c_d.flg.fall_seen = 1'b1;
            if (edge_kept && c_q.ctrl.ovf_en) c_d.flg.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign irq       = c_q.ctrl.int_en & c_q.flg.edge_f;
    assign ctrl_byte = {3'b000, c_q.ctrl};
    assign stat_byte = {3'b000, c_q.flg.fall_seen, c_q.flg.rise_seen, irq,
                        c_q.flg.ovf, c_q.flg.edge_f};

    always_comb begin
        if (bus_addr == ADDR_W'(ADDR_STATUS))       bus_rdata = stat_byte;
        else if (bus_addr == ADDR_W'(ADDR_CONTROL)) bus_rdata = ctrl_byte;
        else if (port_rd_hit)                       bus_rdata = port_rd_data;
        else                                        bus_rdata = 8'h00;
    end
endmodule

// File: rtl/eiu_checker.sv
module eiu_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wd_bit3,
    input logic              c_det,
    input logic              c_ovf,
    input logic              c_int,
    input logic              c_rise,
    input logic              c_fall,
    input logic              s_edge,
    input logic              s_ovf,
    input logic              s_rise,
    input logic              s_fall
);
    AST_EDGE_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_edge) |-> $past(bus_wr && bus_addr == ADDR_W'(1) && wd_bit3)); // R7

    AST_SEEN_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rise || s_fall) |-> s_edge); // R7

    AST_OVF_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_ovf) |-> ($past(c_ovf) && $past(s_edge))); // R8

    AST_EDGE_NEEDS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_edge) |-> ($past(c_det) && ($past(c_rise) || $past(c_fall)))); // R5

    AST_RISE_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_rise) |-> $past(c_rise)); // R3

    AST_FALL_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_fall) |-> $past(c_fall)); // R4

    AST_IRQ_DROP_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_wr)); // R6

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> c_int); // R6
endmodule

bind edge_irq_unit eiu_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .wd_bit3 (bus_wdata[3]),
    .c_det   (ctrl_byte[0]),
    .c_ovf   (ctrl_byte[1]),
    .c_int   (ctrl_byte[2]),
    .c_rise  (ctrl_byte[3]),
    .c_fall  (ctrl_byte[4]),
    .s_edge  (stat_byte[0]),
    .s_ovf   (stat_byte[1]),
    .s_rise  (stat_byte[3]),
    .s_fall  (stat_byte[4])
);

// File: tb/sim_edge_irq_unit.sv
`timescale 1ns/100ps
module sim_edge_irq_unit;
    localparam int NP = 4;
    localparam int CH = NP * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CH-1:0] in_raw = '0;
    logic [7:0]    bus_addr = 8'h00;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    event  mon_ev;

    always #2.5 clk = ~clk;

    edge_irq_unit #(.NUM_PORTS(NP), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .in_raw(in_raw), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // monitor: pops the expectation and compares with the port value
    initial begin
        forever begin
            @(mon_ev);
            #0.5;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {7'b0, irq} : bus_rdata;
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic exp_reg(input logic [7:0] a, input logic [7:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        -> mon_ev;
        #1;
    endtask

    task automatic exp_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        -> mon_ev;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        exp_reg(8'h02, 8'h00, "R1 status");
        exp_reg(8'h03, 8'h00, "R1 control");
        exp_reg(8'h42, 8'h00, "R1 rise arm");
        exp_irq(1'b0, "R1 irq");

        // R2 arm registers: ch10 rise, ch15 fall, ch24 rise
        wr(8'h52, 8'h04);
        wr(8'h53, 8'h80);
        wr(8'h72, 8'h01);
        exp_reg(8'h52, 8'h04, "R2 port1 rise");
        exp_reg(8'h53, 8'h80, "R2 port1 fall");
        exp_reg(8'h72, 8'h01, "R2 port3 rise");
        exp_reg(8'h73, 8'h00, "R2 port3 fall");

        wr(8'h03, 8'h1D);
        exp_reg(8'h03, 8'h1D, "R2 control readback");

        // R10 latency, R3 rise
        in_raw[10] = 1'b1;
        step(2);
        exp_reg(8'h02, 8'h00, "R10 not yet visible");
        step(1);
        exp_reg(8'h02, 8'h0D, "R3 rise flags");
        exp_irq(1'b1, "R6 irq on");

        // R7 clear semantics
        wr(8'h01, 8'h00);
        exp_reg(8'h02, 8'h0D, "R7 zero write no effect");
        wr(8'h01, 8'h08);
        exp_reg(8'h02, 8'h00, "R7 edge clear");
        exp_irq(1'b0, "R6 irq off after clear");

        // R5 unarmed direction, R4 fall
        in_raw[15] = 1'b1; step(3);
        exp_reg(8'h02, 8'h00, "R5 rise on fall-only channel");
        in_raw[15] = 1'b0; step(3);
        exp_reg(8'h02, 8'h15, "R4 fall flags");
        wr(8'h01, 8'h08);
        in_raw[10] = 1'b0; step(3);
        exp_reg(8'h02, 8'h00, "R5 fall on rise-only channel");

        // R8 overflow enabled
        wr(8'h03, 8'h1F);
        in_raw[24] = 1'b1; step(3);
        exp_reg(8'h02, 8'h0D, "R3 first edge port3");
        in_raw[10] = 1'b1; step(3);
        exp_reg(8'h02, 8'h0F, "R8 overflow set");
        wr(8'h01, 8'h04);
        exp_reg(8'h02, 8'h0D, "R7 overflow clear only");
        wr(8'h01, 8'h08);
        exp_reg(8'h02, 8'h00, "R7 edge clear again");

        // R8 overflow disabled
        wr(8'h03, 8'h1D);
        in_raw[10] = 1'b0; in_raw[24] = 1'b0; step(3);
        in_raw[10] = 1'b1; step(3);
        exp_reg(8'h02, 8'h0D, "R3 edge ch10");
        in_raw[24] = 1'b1; step(3);
        exp_reg(8'h02, 8'h0D, "R8 no overflow when disabled");

        // R6 interrupt gating
        wr(8'h03, 8'h19);
        exp_reg(8'h02, 8'h09, "R6 status mirrors masked irq");
        exp_irq(1'b0, "R6 irq masked");
        wr(8'h03, 8'h1D);
        exp_irq(1'b1, "R6 irq unmasked");

        // R9 edge and clear on the same clock edge
        wr(8'h03, 8'h1F);
        wr(8'h01, 8'h08);
        in_raw[10] = 1'b0; in_raw[24] = 1'b0; step(3);
        in_raw[24] = 1'b1; step(3);
        exp_reg(8'h02, 8'h0D, "R9 setup edge");
        in_raw[10] = 1'b1;
        step(2);
        bus_addr = 8'h01; bus_wdata = 8'h0C; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        exp_reg(8'h02, 8'h0D, "R9 set wins, no overflow");

        // R5 control zero blocks all
        wr(8'h03, 8'h00);
        exp_irq(1'b0, "R5 irq off with control zero");
        exp_reg(8'h02, 8'h09, "R6 flags kept, irq bit clear");
        wr(8'h01, 8'h08);
        in_raw[10] = 1'b0; in_raw[24] = 1'b0; step(3);
        in_raw[10] = 1'b1; step(3);
        exp_reg(8'h02, 8'h00, "R5 control zero");

        // R5 global rise off
        wr(8'h03, 8'h15);
        in_raw[10] = 1'b0; step(3);
        in_raw[10] = 1'b1; step(3);
        exp_reg(8'h02, 8'h00, "R5 global rise off");
        exp_irq(1'b0, "R5 irq stays low");

        step(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule